// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter with Bit Slip

The converter samples one serial bit on every rising clock edge and collects the bits into a 4-bit parallel word. One of two serial inputs feeds it, chosen by a select pin, so a test path can be looped back without rewiring. A phase counter paces the captures and also produces two single-cycle enable strobes: one every fourth clock and one every eighth clock. In the narrow mode the word is refreshed every fourth clock. In the wide mode it is refreshed every eighth clock, which lets two instances work side by side as an 8-bit converter.

Word alignment is adjusted with an asynchronous slip input. A two-flop synchroniser samples it, and an edge-detecting state machine turns each pulse into exactly one single-cycle slip request, however long the pulse lasts. A slip request freezes the phase counter for one clock while the shift register keeps shifting. The following capture therefore happens one clock later, and every bit moves down one output position.

The edge state machine has two states. EDGE_LOW goes to EDGE_HIGH when the synchronised slip input is high, and it raises the slip request on that transition. EDGE_HIGH goes back to EDGE_LOW when the synchronised input is low. The conversion mode is decoded into CONV_NIBBLE (mode pin low) or CONV_OCTET (mode pin high), and this chooses which counter phase triggers a capture. A synchronous, active-high reset clears everything and realigns the counter, so several instances released from the same reset stay in step.

Top module: `serial_deser4`

## Requirements
- R1: While `rst` is high, `par_q` is 0 and both strobes are low. After release, the first word is captured at the fourth rising edge that samples data, and `div4_stb` is high in the cycle that follows that edge.
- R2: Within a captured word, the earliest of the four sampled bits appears on `par_q[0]` and the latest on `par_q[3]`.
- R3: With `sel_a` = 1 the converter samples `ser_a`, and with `sel_a` = 0 it samples `ser_b`. The other input has no effect on `par_q`.
- R4: With `mode8` = 0, `par_q` is refreshed exactly once every four clocks (no slip pending), only at edges that also raise `div4_stb`.
- R5: With `mode8` = 1, `par_q` is refreshed once every eight clocks with the last four of the eight sampled bits, and only at edges that also raise `div8_stb`.
- R6: `div4_stb` is a one-cycle pulse every fourth clock and `div8_stb` a one-cycle pulse every eighth clock, in both modes. Every `div8_stb` pulse coincides with a `div4_stb` pulse.
- R7: A `sync_in` pulse held high for at least two clocks causes exactly one slip, whatever its length. The phase counter holds at the third rising edge counted from the first edge that samples `sync_in` high.
- R8: A slip lengthens the current capture interval by one clock. A bit that would have appeared on output position n appears on position n-1 instead, and the shift register does not pause.
- R9: Slips accumulate: each further pulse, separated by at least four low clocks, shifts the alignment by one more position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Serial data input A |
| ser_b | input | 1 | Serial data input B (loopback path) |
| sel_a | input | 1 | 1 selects `ser_a`, 0 selects `ser_b` |
| mode8 | input | 1 | 0: refresh every 4 clocks, 1: refresh every 8 clocks |
| sync_in | input | 1 | Asynchronous slip pulse |
| par_q | output | WORD_W (4) | Parallel word |
| div4_stb | output | 1 | One-cycle strobe every fourth clock |
| div8_stb | output | 1 | One-cycle strobe every eighth clock |

## Verification
`par_q` and both strobes are registered outputs. They change at the same rising edge that samples the fourth bit (or, in wide mode, the eighth bit) of an interval, so they are visible in the cycle right after that edge. A slip shows up three edges after the first edge that samples `sync_in` high: two edges for the synchroniser and one more for the request to freeze the counter. The bench drives all inputs and samples all outputs on the falling edge. It runs a reference model from the requirements in step with the clock and schedules the frozen edge exactly three edges after a pulse starts. It compares outputs every cycle and adds directed checks for the first-word timing, the bit order and the slipped alignment.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;

    typedef enum logic {
        CONV_NIBBLE = 1'b0,
        CONV_OCTET  = 1'b1
    } conv_mode_t;
endpackage

// File: rtl/slip_detect.sv
`timescale 1ns/1ps
module slip_detect
    import deser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_async,
    output logic slip_req
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sync_s;
    edge_state_t            state_q;
    edge_state_t            state_d;

    // Synchroniser chain for the asynchronous slip input
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], sync_async};
    end

    always_comb sync_s = chain_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= EDGE_LOW;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_LOW:  if (sync_s)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!sync_s) state_d = EDGE_LOW;
            default:                state_d = EDGE_LOW;
        endcase
    end

    // Output logic: one request on the EDGE_LOW -> EDGE_HIGH transition
    always_comb begin
        slip_req = 1'b0;
        unique case (state_q)
            EDGE_LOW:  slip_req = sync_s;
            EDGE_HIGH: slip_req = 1'b0;
            default:   slip_req = 1'b0;
        endcase
    end

    // R7
    single_slip_per_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |=> !slip_req);

    // R7
    slip_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |-> (sync_s && !$past(sync_s)));
endmodule

// File: rtl/phase_divider.sv
`timescale 1ns/1ps
module phase_divider #(
    parameter int WORD_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic slip,
    output logic cap_lo,
    output logic cap_hi,
    output logic stb_lo_q,
    output logic stb_hi_q
);
    localparam int CNT_W = $clog2(2 * WORD_W);
    localparam int LO_W  = $clog2(WORD_W);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (!slip) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Capture events fire on the last phase of each interval unless frozen
    always_comb begin
        cap_lo = !slip && (&cnt_q[LO_W-1:0]);
        cap_hi = !slip && (&cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_lo_q <= 1'b0;
            stb_hi_q <= 1'b0;
        end else begin
            stb_lo_q <= cap_lo;
            stb_hi_q <= cap_hi;
        end
    end

    // R8
    slip_freezes_count_chk: assert property (@(posedge clk) disable iff (rst)
        slip |=> (cnt_q == $past(cnt_q)));

    // R6
    wide_inside_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        stb_hi_q |-> stb_lo_q);
endmodule

// File: rtl/word_shifter.sv
`timescale 1ns/1ps
module word_shifter #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              cap,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-2:0] hist_q;
    logic [WORD_W-1:0] hist_next;

    // Newest bit enters at the top, so the oldest ends in bit 0
    always_comb hist_next = {din, hist_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            word_q <= '0;
        end else begin
            hist_q <= hist_next[WORD_W-1:1];
            if (cap) word_q <= hist_next;
        end
    end

    // R4
    word_moves_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_q) |-> ($past(cap) || $past(rst)));
endmodule

// File: rtl/serial_deser4.sv
`timescale 1ns/1ps
module serial_deser4
    import deser_pkg::*;
#(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_a,
    input  logic              ser_b,
    input  logic              sel_a,
    input  logic              mode8,
    input  logic              sync_in,
    output logic [WORD_W-1:0] par_q,
    output logic              div4_stb,
    output logic              div8_stb
);
    logic       bit_in;
    logic       slip_req;
    logic       cap_lo;
    logic       cap_hi;
    logic       cap_en;
    conv_mode_t mode_e;

    always_comb bit_in = sel_a ? ser_a : ser_b;
    always_comb mode_e = conv_mode_t'(mode8);

    always_comb begin
        cap_en = cap_lo;
        unique case (mode_e)
            CONV_NIBBLE: cap_en = cap_lo;
            CONV_OCTET:  cap_en = cap_hi;
            default:     cap_en = cap_lo;
        endcase
    end

    slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
        .clk       (clk),
        .rst       (rst),
        .sync_async(sync_in),
        .slip_req  (slip_req)
    );

    phase_divider #(.WORD_W(WORD_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .slip    (slip_req),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .stb_lo_q(div4_stb),
        .stb_hi_q(div8_stb)
    );

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .din   (bit_in),
        .cap   (cap_en),
        .word_q(par_q)
    );

    // R6
    narrow_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        div4_stb |=> !div4_stb);

    // R5
    wide_refresh_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(par_q) && $past(mode8) && !$past(rst)) |-> div8_stb);

    // R4
    narrow_refresh_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(par_q) && !$past(rst)) |-> div4_stb);
endmodule

// File: tb/test_serial_deser4.sv
`timescale 1ns/1ps
module test_serial_deser4;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_a = 1'b0;
    logic         ser_b = 1'b0;
    logic         sel_a = 1'b1;
    logic         mode8 = 1'b0;
    logic         sync_in = 1'b0;
    logic [W-1:0] par_q;
    logic         div4_stb;
    logic         div8_stb;

    int checks = 0;
    int fails  = 0;

    serial_deser4 #(.WORD_W(W), .SYNC_STAGES(2)) i_serial_deser4 (
        .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .sel_a(sel_a),
        .mode8(mode8), .sync_in(sync_in), .par_q(par_q),
        .div4_stb(div4_stb), .div8_stb(div8_stb)
    );

    always #2.5 clk = ~clk;

    // Reference model built from the requirements
    int           edge_n  = 0;
    int           hold_at = -1;
    int           base    = 0;
    int           m_ph    = 0;
    logic [W-1:0] m_hist  = '0;
    logic [W-1:0] m_q     = '0;
    logic         m_s4    = 1'b0;
    logic         m_s8    = 1'b0;

    always @(posedge clk) begin
        edge_n = edge_n + 1;
        if (rst) begin
            m_ph = 0; m_hist = '0; m_q = '0; m_s4 = 1'b0; m_s8 = 1'b0;
        end else begin
            m_hist = {(sel_a ? ser_a : ser_b), m_hist[W-1:1]};
            m_s4 = 1'b0;
            m_s8 = 1'b0;
            if (edge_n != hold_at) begin
                if (m_ph % W == W - 1) begin
                    m_s4 = 1'b1;
                    if (!mode8) m_q = m_hist;
                end
                if (m_ph == 2 * W - 1) begin
                    m_s8 = 1'b1;
                    if (mode8) m_q = m_hist;
                end
                m_ph = (m_ph + 1) % (2 * W);
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // kind 0: random on both inputs; kind 1: one-hot pattern of period W on both
    task automatic step(input string tag, input int kind);
        @(negedge clk);
        chk(tag, par_q, m_q);
        chk("R6 strobes", {2'b00, div8_stb, div4_stb}, {2'b00, m_s8, m_s4});
        if (kind == 0) begin
            ser_a = 1'($urandom());
            ser_b = 1'($urandom());
        end else begin
            ser_a = (((edge_n + 1 - base) % W) == 0);
            ser_b = ser_a;
        end
    endtask

    task automatic do_reset(input logic wide, input logic pick_a);
        @(negedge clk);
        rst = 1'b1; sync_in = 1'b0; hold_at = -1;
        mode8 = wide; sel_a = pick_a; ser_a = 1'b0; ser_b = 1'b0;
        repeat (2) step("R1 reset", 0);
        chk("R1 reset word", par_q, '0);
        chk("R1 reset strobes", {2'b00, div8_stb, div4_stb}, '0);
        rst = 1'b0;
        base = edge_n + 1;
    endtask

    task automatic slip_pulse(input int len, input string tag, input int kind);
        sync_in = 1'b1;
        hold_at = edge_n + 3;
        repeat (len) step(tag, kind);
        sync_in = 1'b0;
        repeat (6) step(tag, kind);
    endtask

    task automatic t_order;
        do_reset(1'b0, 1'b1);
        ser_a = 1'b1; ser_b = 1'b0;
        @(negedge clk); chk("R1 no early strobe", {3'b000, div4_stb}, '0);
        ser_a = 1'b1;
        @(negedge clk); ser_a = 1'b0;
        @(negedge clk); chk("R1 no early word", par_q, '0);
        ser_a = 1'b1;
        @(negedge clk);
        chk("R2 bit order", par_q, 4'b1011);
        chk("R1 first strobe", {3'b000, div4_stb}, 4'b0001);
        repeat (20) step("R2 random", 0);
    endtask

    task automatic t_select;
        do_reset(1'b0, 1'b0);
        repeat (40) step("R3 input B", 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ser_a = 1'b1; ser_b = 1'b0;
        end
        @(negedge clk);
        chk("R3 unselected ignored", par_q, 4'b0000);
        sel_a = 1'b1;
        repeat (24) step("R3 input A", 0);
    endtask

    task automatic t_narrow;
        do_reset(1'b0, 1'b1);
        repeat (48) step("R4 narrow", 0);
    endtask

    task automatic t_wide;
        int gap;
        do_reset(1'b1, 1'b1);
        repeat (64) step("R5 wide", 0);
        while (!div8_stb) step("R5 wide", 0);
        gap = 0;
        do begin
            step("R5 wide", 0);
            gap++;
        end while (!div8_stb);
        chk("R6 wide period", 4'(gap), 4'd8);
        slip_pulse(3, "R8 wide slip", 0);
        repeat (24) step("R8 wide after", 0);
    endtask

    task automatic t_slip;
        do_reset(1'b0, 1'b1);
        ser_a = 1'b1; ser_b = 1'b1;
        repeat (15) step("R2 pattern", 1);
        while (!div4_stb) step("R2 pattern", 1);
        chk("R2 aligned word", par_q, 4'b0001);
        slip_pulse(2, "R7 short pulse", 1);
        repeat (8) step("R8 slipped", 1);
        chk("R8 one slip", par_q, 4'b1000);
        slip_pulse(9, "R7 long pulse", 1);
        repeat (8) step("R9 slipped", 1);
        chk("R7 long pulse one slip", par_q, 4'b0100);
        slip_pulse(4, "R9 third pulse", 1);
        repeat (8) step("R9 slipped", 1);
        chk("R9 accumulate", par_q, 4'b0010);
        slip_pulse(2, "R9 random", 0);
        repeat (16) step("R9 random after", 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_order();
        t_select();
        t_narrow();
        t_wide();
        t_slip();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule